// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master from the peripheral clock. It pulls the SCL line low or lets it go (open-drain), and it reads the actual line level back. The length of each low phase and each high phase is a multiple of a programmed 12-bit period value. The multiple depends on one of three timing modes: standard with a 1:1 high:low ratio, fast with a 1:2 ratio, and fast with a 9:16 ratio. Any period value below the legal floor of the selected mode is raised to that floor.

Reading the line back gives the block two behaviours. A slow rising edge is absorbed into the high phase, up to a programmed rise limit. A slave that holds SCL low past that limit stretches the clock for as long as it holds. The master controller starts and stops the clock through a run input. A separate enable gates the whole block. The timing and rise-limit settings accept writes only while the enable is low. Two strobes, one at the start of each high phase and one at the start of each low phase, let the controller line up data and START/STOP changes with SCL.

Top module: `scl_clock_gen`

## Requirements
- R1: Standard mode (`cfg_fast`=0) holds SCL low for P cycles and releases it for P cycles, where P is the clamped period value. `cfg_duty916` has no effect in this mode.
- R2: Fast mode with `cfg_duty916`=0 gives a high phase of P cycles and a low phase of 2·P cycles.
- R3: Fast mode with `cfg_duty916`=1 gives a high phase of 9·P cycles and a low phase of 16·P cycles.
- R4: The effective period P is the programmed value raised to a floor. The floor is 1 in fast 9:16 mode and 4 in the other two modes. The period field resets to 0, so the out-of-reset timing is 4/4 cycles.
- R5: A write strobe on `cfg_wr_timing` or `cfg_wr_rise` takes effect only while `enable` is 0. While `enable` is 1, both writes are dropped and the timing seen at SCL does not change.
- R6: The rise limit R resets to 2. If SCL reads low for h ≤ R cycles after release and h is less than the high length, the released phase still lasts exactly the high length.
- R7: If SCL reads low for h > R cycles after release, the released phase lasts h + high length − R cycles. This is clock stretching.
- R8: When `enable` or `run` is sampled low, SCL is released and both strobes stay low from the next cycle on. The next start always begins with a low phase, one cycle after `enable` and `run` are both sampled high.
- R9: `low_start` is high for exactly the first cycle of each low phase. `high_start` is high for exactly the first cycle of each released phase. The two strobes are never high together.
- R10: `scl_drive_low` is 1 during the low phase and 0 at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable. Settings can be written only while this is 0 |
| run | input | 1 | Request from the master controller to toggle SCL |
| cfg_wr_timing | input | 1 | Write strobe for the mode bits and the period value |
| cfg_fast | input | 1 | 0 selects standard mode, 1 selects fast mode |
| cfg_duty916 | input | 1 | In fast mode, 1 selects the 9:16 ratio |
| cfg_period | input | 12 | Period value P before the floor is applied |
| cfg_wr_rise | input | 1 | Write strobe for the rise limit |
| cfg_rise | input | 6 | Rise limit R, in cycles |
| scl_in | input | 1 | SCL line level as read back |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| high_start | output | 1 | First cycle of a released phase |
| low_start | output | 1 | First cycle of a low phase |

## Verification
A phase counter in the wrong state shows up at SCL as a phase of the wrong length. It becomes visible at the very next strobe, so the bench measures each low and high length from strobe to strobe and compares it against the mode formula. A lock that leaks shows up as changed timing on the first period after a blocked write. A rise limit that is handled wrongly only appears when the line is held low after release. For that reason a modelled slave holds the line low both inside and beyond the limit, and the bench checks the released length against h + high − R on that same period.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;

   typedef struct packed {
      logic fast;
      logic duty;
   } mode_t;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
   import scl_gen_pkg::*;
#(
   parameter int CCR_W    = 12,
   parameter int RISE_W   = 6,
   parameter int RISE_RST = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_timing,
   input  logic              wr_fast,
   input  logic              wr_duty,
   input  logic [CCR_W-1:0]  wr_period,
   input  logic              wr_rise,
   input  logic [RISE_W-1:0] wr_rise_val,
   output mode_t             mode_q,
   output logic [CCR_W-1:0]  period_q,
   output logic [RISE_W-1:0] rise_q
);

   localparam logic [RISE_W-1:0] RISE_INIT = RISE_W'(RISE_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         period_q <= '0;
         rise_q   <= RISE_INIT;
      end else if (!enable) begin
         if (wr_timing) begin
            mode_q.fast <= wr_fast;
            mode_q.duty <= wr_duty;
            period_q    <= wr_period;
         end
         if (wr_rise) begin
            rise_q <= wr_rise_val;
         end
      end
   end

   // R5: nothing written while enabled
   assert_cfg_lock_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> ($stable(period_q) && $stable(rise_q) && $stable(mode_q)));

endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len
   import scl_gen_pkg::*;
#(
   parameter int CCR_W      = 12,
   parameter int LEN_W      = 16,
   parameter int MULT_STYLE = 0
) (
   input  mode_t             mode,
   input  logic [CCR_W-1:0]  period,
   output logic [LEN_W-1:0]  high_len,
   output logic [LEN_W-1:0]  low_len
);

   localparam logic [CCR_W-1:0] FLOOR_SLOW = CCR_W'(4);
   localparam logic [CCR_W-1:0] FLOOR_916  = CCR_W'(1);

   logic             use_916;
   logic [CCR_W-1:0] floor_v;
   logic [CCR_W-1:0] p_eff;
   logic [LEN_W-1:0] p_ext;

   always_comb begin
      use_916 = mode.fast & mode.duty;
      floor_v = use_916 ? FLOOR_916 : FLOOR_SLOW;
      p_eff   = (period < floor_v) ? floor_v : period;
      p_ext   = LEN_W'(p_eff);
   end

   generate
      if (MULT_STYLE == 0) begin : g_shift_add
         always_comb begin
            if (!mode.fast) begin
               high_len = p_ext;
               low_len  = p_ext;
            end else if (!mode.duty) begin
               high_len = p_ext;
               low_len  = p_ext << 1;
            end else begin
               high_len = (p_ext << 3) + p_ext;
               low_len  = p_ext << 4;
            end
         end
      end else begin : g_multiply
         logic [LEN_W-1:0] hi_mul;
         logic [LEN_W-1:0] lo_mul;
         always_comb begin
            hi_mul   = (!mode.fast) ? LEN_W'(1) : (mode.duty ? LEN_W'(9)  : LEN_W'(1));
            lo_mul   = (!mode.fast) ? LEN_W'(1) : (mode.duty ? LEN_W'(16) : LEN_W'(2));
            high_len = p_ext * hi_mul;
            low_len  = p_ext * lo_mul;
         end
      end
   endgenerate

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
   import scl_gen_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int RISE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              scl_in,
   input  logic [LEN_W-1:0]  high_len,
   input  logic [LEN_W-1:0]  low_len,
   input  logic [RISE_W-1:0] rise_lim,
   output logic              drive_low,
   output logic              high_start,
   output logic              low_start
);

   phase_e           ph_q;
   phase_e           ph_prev_q;
   logic [LEN_W-1:0] cnt_q;
   logic             seen_q;
   logic [LEN_W-1:0] rise_ext;
   logic             waiting;

   always_comb begin
      rise_ext = LEN_W'(rise_lim);
      waiting  = !seen_q && !scl_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= PH_IDLE;
         ph_prev_q <= PH_IDLE;
         cnt_q     <= '0;
         seen_q    <= 1'b0;
      end else begin
         ph_prev_q <= ph_q;
         if (!active) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            seen_q <= 1'b0;
         end else begin
            unique case (ph_q)
               PH_IDLE: begin
                  ph_q  <= PH_LOW;
                  cnt_q <= '0;
               end
               PH_LOW: begin
                  if (cnt_q >= low_len - 1'b1) begin
                     ph_q   <= PH_HIGH;
                     cnt_q  <= '0;
                     seen_q <= 1'b0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               PH_HIGH: begin
                  if (waiting) begin
                     if (cnt_q < rise_ext) begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end else begin
                     seen_q <= 1'b1;
                     if (cnt_q >= high_len - 1'b1) begin
                        ph_q  <= PH_LOW;
                        cnt_q <= '0;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               default: begin
                  ph_q  <= PH_IDLE;
                  cnt_q <= '0;
               end
            endcase
         end
      end
   end

   assign drive_low  = (ph_q == PH_LOW);
   assign low_start  = (ph_q == PH_LOW)  && (ph_prev_q != PH_LOW);
   assign high_start = (ph_q == PH_HIGH) && (ph_prev_q != PH_HIGH);

   // R8: inactive means released line and silent strobes next cycle
   assert_idle_release_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!drive_low && !high_start && !low_start));

   // R9: strobes never coincide
   assert_strobe_onehot_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({high_start, low_start}));

   // R10: every pull-down begins with a low-phase strobe
   assert_low_entry_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_low) |-> low_start);

   // R1: the low counter stays inside the programmed length
   assert_low_bound_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_LOW) |-> (cnt_q < low_len));

   // R7: a held line beyond the rise limit freezes the high counter
   assert_stretch_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (active && ph_q == PH_HIGH && waiting && cnt_q >= rise_ext)
         |=> (ph_q == PH_HIGH && $stable(cnt_q)));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
   import scl_gen_pkg::*;
#(
   parameter int CCR_W      = 12,
   parameter int RISE_W     = 6,
   parameter int RISE_RST   = 2,
   parameter int MULT_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              run,
   input  logic              cfg_wr_timing,
   input  logic              cfg_fast,
   input  logic              cfg_duty916,
   input  logic [CCR_W-1:0]  cfg_period,
   input  logic              cfg_wr_rise,
   input  logic [RISE_W-1:0] cfg_rise,
   input  logic              scl_in,
   output logic              scl_drive_low,
   output logic              high_start,
   output logic              low_start
);

   localparam int LEN_W = CCR_W + 4;

   initial begin
      if (CCR_W < 3 || CCR_W > 24)
         $fatal(1, "scl_clock_gen: CCR_W out of range");
      if (RISE_W < 1 || RISE_W > LEN_W)
         $fatal(1, "scl_clock_gen: RISE_W out of range");
      if (RISE_RST < 0 || RISE_RST >= (1 << RISE_W))
         $fatal(1, "scl_clock_gen: RISE_RST does not fit");
      if (MULT_STYLE != 0 && MULT_STYLE != 1)
         $fatal(1, "scl_clock_gen: MULT_STYLE must be 0 or 1");
   end

   mode_t             mode_q;
   logic [CCR_W-1:0]  period_q;
   logic [RISE_W-1:0] rise_q;
   logic [LEN_W-1:0]  high_len;
   logic [LEN_W-1:0]  low_len;
   logic              active;

   assign active = enable & run;

   scl_cfg_regs #(
      .CCR_W(CCR_W), .RISE_W(RISE_W), .RISE_RST(RISE_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .wr_timing(cfg_wr_timing), .wr_fast(cfg_fast), .wr_duty(cfg_duty916),
      .wr_period(cfg_period), .wr_rise(cfg_wr_rise), .wr_rise_val(cfg_rise),
      .mode_q(mode_q), .period_q(period_q), .rise_q(rise_q)
   );

   scl_phase_len #(
      .CCR_W(CCR_W), .LEN_W(LEN_W), .MULT_STYLE(MULT_STYLE)
   ) u_len (
      .mode(mode_q), .period(period_q),
      .high_len(high_len), .low_len(low_len)
   );

   scl_phase_seq #(
      .LEN_W(LEN_W), .RISE_W(RISE_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .active(active), .scl_in(scl_in),
      .high_len(high_len), .low_len(low_len), .rise_lim(rise_q),
      .drive_low(scl_drive_low), .high_start(high_start), .low_start(low_start)
   );

endmodule

// File: tb/tb_scl_clock_gen.sv
module tb_scl_clock_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        run = 1'b0;
   logic        wr_t = 1'b0;
   logic        fast = 1'b0;
   logic        duty = 1'b0;
   logic [11:0] period = '0;
   logic        wr_r = 1'b0;
   logic [5:0]  rise = '0;
   logic        scl_in;
   logic        drv;
   logic        hs;
   logic        ls;

   int rel_cnt = 0;
   int hold_cfg = 0;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   // Line model: released line reads low while the slave holds it.
   always @(posedge clk) rel_cnt <= drv ? 0 : rel_cnt + 1;
   assign scl_in = !drv && (rel_cnt >= hold_cfg);

   scl_clock_gen dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
      .cfg_wr_timing(wr_t), .cfg_fast(fast), .cfg_duty916(duty),
      .cfg_period(period), .cfg_wr_rise(wr_r), .cfg_rise(rise),
      .scl_in(scl_in), .scl_drive_low(drv), .high_start(hs), .low_start(ls)
   );

   function automatic int eff_p(bit f, bit d, int p);
      int fl;
      fl = (f && d) ? 1 : 4;
      return (p < fl) ? fl : p;
   endfunction

   function automatic int exp_high(bit f, bit d, int p);
      return (f && d) ? 9 * eff_p(f, d, p) : eff_p(f, d, p);
   endfunction

   function automatic int exp_low(bit f, bit d, int p);
      if (!f) return eff_p(f, d, p);
      return d ? 16 * eff_p(f, d, p) : 2 * eff_p(f, d, p);
   endfunction

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_timing(bit f, bit d, int p);
      @(negedge clk);
      fast = f; duty = d; period = 12'(p); wr_t = 1'b1;
      @(negedge clk);
      wr_t = 1'b0;
   endtask

   task automatic set_rise(int r);
      @(negedge clk);
      rise = 6'(r); wr_r = 1'b1;
      @(negedge clk);
      wr_r = 1'b0;
   endtask

   task automatic start_gen();
      @(negedge clk);
      enable = 1'b1; run = 1'b1;
   endtask

   task automatic stop_gen();
      @(negedge clk);
      enable = 1'b0; run = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // Called at a negedge; measures one low phase then one released phase.
   task automatic measure(output int lo, output int hi);
      int w;
      w = 0;
      while (!ls && w < 100000) begin
         @(negedge clk);
         w++;
      end
      lo = 0;
      do begin
         lo++;
         @(negedge clk);
      end while (!hs && lo < 100000);
      hi = 0;
      do begin
         hi++;
         @(negedge clk);
      end while (!ls && hi < 100000);
   endtask

   task automatic run_and_check(string req, bit f, bit d, int p);
      int lo, hi;
      set_timing(f, d, p);
      start_gen();
      measure(lo, hi);
      check({req, " low"}, lo, exp_low(f, d, p));
      check({req, " high"}, hi, exp_high(f, d, p));
      stop_gen();
   endtask

   initial begin
      int lo, hi, bad;
      void'($urandom(32'h5C1C0DE));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8/R10: released and silent after reset while idle
      check("R10 reset drive", int'(drv), 0);
      check("R9 reset strobes", int'({hs, ls}), 0);

      // R4: out-of-reset period 0 clamps to 4/4
      start_gen();
      measure(lo, hi);
      check("R4 reset low", lo, 4);
      check("R4 reset high", hi, 4);
      // R8: dropping run releases the line and silences strobes
      @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (drv || hs || ls) bad++;
      end
      check("R8 run low idle", bad, 0);
      // R8: restart begins with a low phase one cycle later
      run = 1'b1;
      @(negedge clk);
      check("R8 restart low_start", int'(ls), 1);
      check("R10 restart drive", int'(drv), 1);
      stop_gen();

      run_and_check("R1 std 0x28", 1'b0, 1'b0, 40);
      run_and_check("R2 fast 1:2", 1'b1, 1'b0, 30);
      run_and_check("R3 fast 9:16", 1'b1, 1'b1, 3);
      run_and_check("R4 clamp 9:16 p0", 1'b1, 1'b1, 0);
      run_and_check("R4 floor 9:16 p1", 1'b1, 1'b1, 1);
      run_and_check("R4 clamp std p3", 1'b0, 1'b0, 3);
      run_and_check("R4 clamp fast p1", 1'b1, 1'b0, 1);
      run_and_check("R1 std duty ignored", 1'b0, 1'b1, 7);

      // R5: writes while enabled are dropped
      set_timing(1'b0, 1'b0, 10);
      start_gen();
      @(negedge clk);
      fast = 1'b1; duty = 1'b1; period = 12'd50; wr_t = 1'b1;
      rise = 6'd30; wr_r = 1'b1;
      @(negedge clk);
      wr_t = 1'b0; wr_r = 1'b0;
      measure(lo, hi);
      check("R5 locked low", lo, 10);
      check("R5 locked high", hi, 10);
      stop_gen();

      // R6/R7 with the reset rise limit 2 (the write above must not land: R5)
      set_timing(1'b0, 1'b0, 20);
      hold_cfg = 2;
      start_gen();
      measure(lo, hi);
      check("R6 slow rise absorbed", hi, 20);
      stop_gen();
      hold_cfg = 9;
      start_gen();
      measure(lo, hi);
      check("R7 stretch R=2 (R5 rise lock)", hi, 9 + 20 - 2);
      check("R7 low unaffected", lo, 20);
      stop_gen();
      set_rise(12);
      hold_cfg = 9;
      start_gen();
      measure(lo, hi);
      check("R6 rise limit 12", hi, 20);
      stop_gen();
      hold_cfg = 15;
      start_gen();
      measure(lo, hi);
      check("R7 stretch R=12", hi, 15 + 20 - 12);
      stop_gen();
      hold_cfg = 0;

      // Random modes and periods (R1/R2/R3/R4)
      for (int i = 0; i < 16; i++) begin
         int m, p;
         m = int'($urandom % 4);
         case (m)
            0: begin p = int'($urandom % 50); run_and_check("R1 rand", 1'b0, 1'b0, p); end
            1: begin p = int'($urandom % 50); run_and_check("R2 rand", 1'b1, 1'b0, p); end
            2: begin p = int'($urandom % 20); run_and_check("R3 rand", 1'b1, 1'b1, p); end
            default: begin p = int'($urandom % 50); run_and_check("R1 rand duty", 1'b0, 1'b1, p); end
         endcase
      end

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule